// File: doc/BRIEF.md
# Chained Partial-Sum Beamformer Node

This block is one stage of a chain that forms several receive beams from a large array without any single stage seeing every channel. Each node owns a fixed group of C array channels. For one range gate it takes the C complex channel samples one per beat, multiplies each by a stored complex weight for every one of B beams at once, and adds the products up. It then adds the partial beam sums handed over by the upstream node for that same range gate and passes the totals downstream. The last node in the chain therefore delivers the finished beams.

Weights are worked out elsewhere and written into a register file before streaming starts. Writes are refused while a range gate is in progress. A node placed at the head of the chain is told so by a static input. It then treats its upstream sum as zero and never waits on the upstream port. All arithmetic is signed fixed point, and the accumulators carry enough extra bits that the chain total is exact.

Top module: `bf_node`

## Requirements
- R1: After reset, s_ready and wl_ready are 1, while d_valid and u_ready are 0.
- R2: A weight write completes when wl_valid and wl_ready are both 1. It stores wl_re/wl_im for the pair (wl_chan, wl_beam). A write whose beam index is B or greater changes no stored weight.
- R3: For each beam b, the output equals the upstream value plus the sum over channels c of sample(c) times weight(c,b). The real part is sr*wr - si*wi and the imaginary part is sr*wi + si*wr. The result is exact in AW-bit two's complement, including full-scale inputs of -32768.
- R4: A range gate is exactly C accepted sample beats. Beat k carries channel k. Each new gate accumulates from zero, so nothing carries over from the previous gate.
- R5: s_ready drops after the C-th sample of a gate is accepted. It stays low until that gate's output has been accepted downstream.
- R6: When the node is not the chain head, u_ready is 1 only once the local sums for the gate are complete. d_valid stays 0 until an upstream beat is accepted, and it rises on the clock edge right after that acceptance.
- R7: With head_mode at 1, u_ready stays 0 and upstream data has no effect. d_valid rises on the second clock edge after the last sample is accepted.
- R8: While d_valid is 1 and d_ready is 0, d_valid and d_data hold steady.
- R9: wl_ready is 0 from the first sample of a gate until that gate's output is accepted. Writes attempted in that window are ignored.
- R10: In u_data and d_data, beam b occupies bits [2*b*AW +: AW] for the real part and [(2*b+1)*AW +: AW] for the imaginary part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_mode | input | 1 | Static; 1 marks the first node of the chain |
| wl_valid | input | 1 | Weight write request |
| wl_ready | output | 1 | Weight port accepts writes |
| wl_chan | input | CW | Channel index of the weight |
| wl_beam | input | BW | Beam index of the weight |
| wl_re | input | DW | Weight real part, signed |
| wl_im | input | DW | Weight imaginary part, signed |
| s_valid | input | 1 | Channel sample valid |
| s_ready | output | 1 | Channel sample accepted |
| s_re | input | DW | Sample real part, signed |
| s_im | input | DW | Sample imaginary part, signed |
| u_valid | input | 1 | Upstream partial sums valid |
| u_ready | output | 1 | Upstream partial sums accepted |
| u_data | input | 2*B*AW | Upstream partial sums, packed per R10 |
| d_valid | output | 1 | Downstream sums valid |
| d_ready | input | 1 | Downstream accepts sums |
| d_data | output | 2*B*AW | Downstream sums, packed per R10 |

## Verification
Two kinds of internal fault show up at the ports. A stale accumulator or a wrong channel count corrupts the very next d_data, or shifts the cycle in which d_valid rises. Either appears within one gate, about C+2 cycles. A bad weight index or a write that leaks through during a gate stays hidden until a gate uses that channel and beam, and then every later gate is wrong for that beam alone. For that reason the bench replays random gates after each weight-port corner case, and it checks every beam slice against an independently computed sum.

// File: rtl/bf_node.sv
module bf_node #(
  parameter int C  = 4,
  parameter int B  = 3,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int CW = (C > 1) ? $clog2(C) : 1,
  localparam int BW = (B > 1) ? $clog2(B + 1) : 1,
  localparam int OW = 2 * B * AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_mode,
  input  logic                 wl_valid,
  output logic                 wl_ready,
  input  logic [CW-1:0]        wl_chan,
  input  logic [BW-1:0]        wl_beam,
  input  logic signed [DW-1:0] wl_re,
  input  logic signed [DW-1:0] wl_im,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_re,
  input  logic signed [DW-1:0] s_im,
  input  logic                 u_valid,
  output logic                 u_ready,
  input  logic [OW-1:0]        u_data,
  output logic                 d_valid,
  input  logic                 d_ready,
  output logic [OW-1:0]        d_data
);
  localparam int PW = 2 * DW;

  typedef enum logic [1:0] {ST_ACC, ST_WAIT, ST_OUT} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic s_fire, take, last;

  logic signed [DW-1:0] w_re [C*B];
  logic signed [DW-1:0] w_im [C*B];

  assign s_ready  = (st == ST_ACC);
  assign wl_ready = (st == ST_ACC) && (cnt == '0);
  assign u_ready  = (st == ST_WAIT) && !head_mode;
  assign d_valid  = (st == ST_OUT);
  assign s_fire   = s_valid && s_ready;
  assign take     = (st == ST_WAIT) && (head_mode || u_valid);
  assign last     = (cnt == CW'(C - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_ACC;
      cnt <= '0;
    end else begin
      case (st)
        ST_ACC: if (s_fire) begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= ST_WAIT;
        end
        ST_WAIT: if (take) st <= ST_OUT;
        ST_OUT:  if (d_ready) st <= ST_ACC;
        default: st <= ST_ACC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wl_valid && wl_ready && (int'(wl_beam) < B) && (int'(wl_chan) < C)) begin
      w_re[int'(wl_chan) * B + int'(wl_beam)] <= wl_re;
      w_im[int'(wl_chan) * B + int'(wl_beam)] <= wl_im;
    end
  end

  for (genvar b = 0; b < B; b++) begin : g_beam
    logic signed [DW-1:0] cw_re, cw_im;
    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [AW-1:0] p_re, p_im, acc_re, acc_im, up_re, up_im, sum_re, sum_im;

    assign cw_re = w_re[int'(cnt) * B + b];
    assign cw_im = w_im[int'(cnt) * B + b];
    assign m_rr  = PW'(s_re) * PW'(cw_re);
    assign m_ii  = PW'(s_im) * PW'(cw_im);
    assign m_ri  = PW'(s_re) * PW'(cw_im);
    assign m_ir  = PW'(s_im) * PW'(cw_re);
    assign p_re  = AW'(m_rr) - AW'(m_ii);
    assign p_im  = AW'(m_ri) + AW'(m_ir);
    assign up_re = head_mode ? '0 : u_data[2*b*AW +: AW];
    assign up_im = head_mode ? '0 : u_data[(2*b+1)*AW +: AW];

    always_ff @(posedge clk) begin
      if (s_fire) begin
        acc_re <= ((cnt == '0) ? '0 : acc_re) + p_re;
        acc_im <= ((cnt == '0) ? '0 : acc_im) + p_im;
      end
      if (take) begin
        sum_re <= acc_re + up_re;
        sum_im <= acc_im + up_im;
      end
    end

    assign d_data[2*b*AW +: AW]     = sum_re;
    assign d_data[(2*b+1)*AW +: AW] = sum_im;
  end
endmodule

// File: rtl/bf_node_chk.sv
module bf_node_chk #(
  parameter int C  = 4,
  parameter int B  = 3,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int OW = 2 * B * AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_mode,
  input logic          wl_ready,
  input logic          s_valid,
  input logic          s_ready,
  input logic          u_valid,
  input logic          u_ready,
  input logic          d_valid,
  input logic          d_ready,
  input logic [OW-1:0] d_data
);
  int beats;
  always_ff @(posedge clk) begin
    if (!rst_n) beats <= 0;
    else if (s_valid && s_ready) beats <= (beats == C - 1) ? 0 : beats + 1;
  end

  a_r5_in_out_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && d_valid));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_data));
  a_r7_head_no_up: assert property (@(posedge clk) disable iff (!rst_n)
    head_mode |-> !u_ready);
  a_r6_emit_after_up: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid && u_ready |=> d_valid);
  a_r4_whole_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_valid) |-> beats == 0);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    beats != 0 |-> !wl_ready);
endmodule

bind bf_node bf_node_chk #(.C(C), .B(B), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_mode(head_mode), .wl_ready(wl_ready),
  .s_valid(s_valid), .s_ready(s_ready), .u_valid(u_valid), .u_ready(u_ready),
  .d_valid(d_valid), .d_ready(d_ready), .d_data(d_data));

// File: tb/tb_bf_node.sv
module tb_bf_node;
  localparam int C = 4, B = 3, DW = 16, AW = 40;
  localparam int CW = 2, BW = 2, OW = 2 * B * AW;

  logic clk = 0, rst_n = 0, head_mode = 0;
  logic wl_valid = 0, wl_ready;
  logic [CW-1:0] wl_chan = '0;
  logic [BW-1:0] wl_beam = '0;
  logic signed [DW-1:0] wl_re = '0, wl_im = '0, s_re = '0, s_im = '0;
  logic s_valid = 0, s_ready, u_valid = 0, u_ready, d_valid, d_ready = 0;
  logic [OW-1:0] u_data = '0, d_data, snap;

  always #10 clk = ~clk;

  bf_node #(.C(C), .B(B), .DW(DW), .AW(AW)) dut (.*);

  int errors = 0, checks = 0;
  longint mwr [C][B], mwi [C][B];
  longint sr [C], si [C], ur [B], ui [B];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  function automatic longint slice(input int b, input int part);
    logic signed [AW-1:0] v;
    v = d_data[(2*b+part)*AW +: AW];
    return longint'(v);
  endfunction

  task automatic load_w(input int c, input int b, input longint re, input longint im, input bit model);
    @(negedge clk);
    wl_valid = 1; wl_chan = CW'(c); wl_beam = BW'(b);
    wl_re = DW'(re); wl_im = DW'(im);
    while (!wl_ready) @(negedge clk);
    @(posedge clk); #1 wl_valid = 0;
    if (model) begin mwr[c][b] = re; mwi[c][b] = im; end
  endtask

  task automatic send(input int lo, input int hi);
    for (int c = lo; c <= hi; c++) begin
      @(negedge clk);
      s_valid = 1; s_re = DW'(sr[c]); s_im = DW'(si[c]);
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1 s_valid = 0;
    end
  endtask

  task automatic finish_gate(input int up_delay, input int hold);
    longint er, ei;
    if (head_mode) begin
      chk(d_valid == 0, "R7 d_valid one edge after last sample", d_valid, 0);
      chk(u_ready == 0, "R7 u_ready in head mode", u_ready, 0);
      @(negedge clk);
      u_valid = 1;
      for (int b = 0; b < B; b++) u_data[2*b*AW +: 2*AW] = {2*AW{1'b1}};
      @(posedge clk); #1 u_valid = 0;
      chk(d_valid == 1, "R7 d_valid two edges after last sample", d_valid, 1);
    end else begin
      for (int k = 0; k < up_delay; k++) begin
        @(negedge clk);
        chk(d_valid == 0, "R6 no output before upstream", d_valid, 0);
        chk(s_ready == 0, "R5 s_ready low after C-th sample", s_ready, 0);
      end
      @(negedge clk);
      u_valid = 1;
      for (int b = 0; b < B; b++) begin
        u_data[2*b*AW +: AW] = AW'(ur[b]);
        u_data[(2*b+1)*AW +: AW] = AW'(ui[b]);
      end
      chk(u_ready == 1, "R6 u_ready once local sums done", u_ready, 1);
      @(posedge clk); #1 u_valid = 0;
      chk(d_valid == 1, "R6 d_valid after upstream accepted", d_valid, 1);
    end
    for (int b = 0; b < B; b++) begin
      er = head_mode ? 0 : ur[b];
      ei = head_mode ? 0 : ui[b];
      for (int c = 0; c < C; c++) begin
        er += sr[c] * mwr[c][b] - si[c] * mwi[c][b];
        ei += sr[c] * mwi[c][b] + si[c] * mwr[c][b];
      end
      chk(slice(b, 0) == er, $sformatf("R3 R10 beam %0d real", b), slice(b, 0), er);
      chk(slice(b, 1) == ei, $sformatf("R3 R10 beam %0d imag", b), slice(b, 1), ei);
    end
    snap = d_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(d_valid == 1 && d_data == snap, "R8 output held under backpressure", d_valid, 1);
    end
    @(negedge clk); d_ready = 1;
    @(posedge clk); #1 d_ready = 0;
    chk(d_valid == 0 && s_ready == 1, "R5 s_ready back after output accepted", s_ready, 1);
  endtask

  task automatic rand_gate();
    for (int c = 0; c < C; c++) begin
      sr[c] = longint'($signed(16'($urandom())));
      si[c] = longint'($signed(16'($urandom())));
    end
    for (int b = 0; b < B; b++) begin
      ur[b] = longint'($signed(32'($urandom()))) * 4;
      ui[b] = longint'($signed(32'($urandom()))) * 4;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(s_ready == 1, "R1 s_ready after reset", s_ready, 1);
    chk(wl_ready == 1, "R1 wl_ready after reset", wl_ready, 1);
    chk(d_valid == 0, "R1 d_valid after reset", d_valid, 0);
    chk(u_ready == 0, "R1 u_ready after reset", u_ready, 0);

    // R3 full-scale corner: every product at its extreme
    for (int c = 0; c < C; c++)
      for (int b = 0; b < B; b++) load_w(c, b, -32768, -32768, 1);
    for (int c = 0; c < C; c++) begin sr[c] = -32768; si[c] = -32768; end
    for (int b = 0; b < B; b++) begin ur[b] = -(longint'(1) << 37); ui[b] = longint'(1) << 37; end
    send(0, C - 1);
    finish_gate(0, 0);

    // R2 R4 random weights and random gates, chain head and middle
    for (int c = 0; c < C; c++)
      for (int b = 0; b < B; b++)
        load_w(c, b, longint'($signed(16'($urandom()))), longint'($signed(16'($urandom()))), 1);
    for (int g = 0; g < 24; g++) begin
      @(negedge clk) head_mode = ($urandom() % 4) == 0;
      rand_gate();
      send(0, C - 1);
      finish_gate(int'($urandom() % 4), int'($urandom() % 4));
    end
    @(negedge clk) head_mode = 0;

    // R2 beam index out of range must not alias another weight
    load_w(0, B, 12345, -999, 0);
    rand_gate();
    send(0, C - 1);
    finish_gate(1, 0);

    // R9 write attempt during a gate is refused
    rand_gate();
    send(0, 1);
    @(negedge clk);
    chk(wl_ready == 0, "R9 wl_ready low mid-gate", wl_ready, 0);
    wl_valid = 1; wl_chan = 2'd2; wl_beam = 2'd1; wl_re = 16'sd777; wl_im = -16'sd777;
    repeat (2) @(negedge clk);
    wl_valid = 0;
    send(2, C - 1);
    finish_gate(2, 1);
    rand_gate();
    send(0, C - 1);
    finish_gate(0, 2);

    repeat (2) @(posedge clk);
    summary();
  end
endmodule